// File: doc/BRIEF.md
# Eight-Slot Flippable Sprite Renderer

This block produces the sprite layer of a tile-and-sprite raster display. Up to eight movable 16x16 objects are described by attribute bytes that the CPU writes into two small address windows. The bytes are held in registers in the block, not in RAM. For every scan position from the raster generator, all eight slots are hit-tested in parallel, and the lowest-numbered slot that covers the pixel is chosen.

The CPU places objects in a frame whose origin is the bottom-right corner, with X counting leftward and Y counting upward. The block turns this into raster coordinates and mirrors the in-object offset when a flip bit is set. It then reads a packed 2-bit pixel from an external sprite pattern ROM and turns it into an 8-bit colour through a palette ROM and a 16-entry colour table. A colour of zero means transparent. A downstream mux shows the background wherever the sprite colour is zero.

Top module: `sprite_layer`

## Requirements
- R1: While `rst` is high, every slot's attributes become zero and `pix_color` becomes 0. With all-zero attributes, no pixel on the screen is covered.
- R2: A write with `cpu_we` high is captured only when `cpu_addr` lies in one of two 16-byte windows: `ATTR_BASE` (default 0x4FF0) or `POS_BASE` (default 0x5060). Within a window, offset bits [3:1] give the slot and offset bit 0 gives the byte. In the attribute window, byte 0 is {pattern[5:0], xflip, yflip} (bits 7:2, 1, 0) and byte 1 is the palette number. In the position window, byte 0 is X and byte 1 is Y. Writes to any other address change nothing.
- R3: A slot with position (X, Y) covers raster columns 208-X to 223-X and rows 272-Y to 287-Y. These bounds wrap modulo 1024, so a sprite with a negative left edge still shows its right part at the left of the screen.
- R4: No sprite pixel is shown in raster rows 0-15 or 272-287. `pix_color` is 0 there.
- R5: When several slots cover a pixel, the slot with the lowest number is used.
- R6: When no slot covers a pixel, `pix_color` is 0.
- R7: With in-object offsets rx = column - left and ry = row - top (after any flip), `spr_rom_addr` = {pattern, ry[3:0], rx[3:2]}. The pixel value is bits [2*rx[1:0]+1 : 2*rx[1:0]] of the returned byte.
- R8: When xflip is 1, rx is replaced by 15-rx. When yflip is 1, ry is replaced by 15-ry.
- R9: `pal_rom_addr` is the low 5 bits of the palette number. The low 4 bits of byte p of the palette word, where p is the pixel value, index the colour table. The colour table is the parameter `CTAB`, and entry i is in bits 8i+7:8i.
- R10: The ROMs return data one clock after the address. `pix_color` for a scan position applied before clock edge n is valid after edge n+1. A CPU write taken at edge n affects scan positions applied after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| pix_x | input | 8 | Raster column, 0 at left |
| pix_y | input | 9 | Raster row, 0 at top |
| spr_rom_addr | output | 12 | Sprite pattern ROM address |
| spr_rom_data | input | 8 | Pattern ROM byte (four 2-bit pixels), one cycle after address |
| pal_rom_addr | output | 5 | Palette ROM address |
| pal_rom_data | input | 32 | Palette word (four bytes), one cycle after address |
| pix_color | output | 8 | Sprite colour, 0 = transparent |

## Verification
A CPU write to a slot can happen in the same cycle as the hit test of a scan position that the same slot covers. The bench provokes this by driving a move of slot 0 off its place and a pixel inside slot 0 on the same clock edge, then holding that pixel one more cycle. The check is that the first result still shows slot 0's colour from the old attributes. The next result must show slot 1, which also covers that pixel and now wins.

// File: rtl/spr_pkg.sv
package spr_pkg;
    localparam int OFS_W   = 4;
    localparam int SPR_DIM = 1 << OFS_W;
    localparam int PAT_W   = 6;

    typedef struct packed {
        logic [7:0]       xpos;
        logic [7:0]       ypos;
        logic [PAT_W-1:0] pat;
        logic             xflip;
        logic             yflip;
        logic [7:0]       pal;
    } spr_attr_t;

    function automatic logic [OFS_W-1:0] mirror_ofs(logic [OFS_W-1:0] v, logic f);
        return f ? (OFS_W'(SPR_DIM - 1) - v) : v;
    endfunction
endpackage

// File: rtl/spr_attr_bank.sv
module spr_attr_bank
    import spr_pkg::*;
#(
    parameter int          N_SPR     = 8,
    parameter logic [15:0] ATTR_BASE = 16'h4FF0,
    parameter logic [15:0] POS_BASE  = 16'h5060
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [15:0]             addr,
    input  logic [7:0]              wdata,
    output spr_attr_t [N_SPR-1:0]   attrs
);
    localparam int WIN = 2 * N_SPR;
    localparam int SLW = $clog2(N_SPR);

    logic [15:0]    off_a, off_p;
    logic           in_attr, in_pos;
    logic [SLW-1:0] slot_a, slot_p;

    always_comb begin
        off_a   = addr - ATTR_BASE;
        off_p   = addr - POS_BASE;
        in_attr = off_a < 16'(WIN);
        in_pos  = off_p < 16'(WIN);
        slot_a  = off_a[SLW:1];
        slot_p  = off_p[SLW:1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            attrs <= '0;
        end else if (we) begin
            if (in_attr) begin
                if (!off_a[0]) begin
                    attrs[slot_a].pat   <= wdata[7:2];
                    attrs[slot_a].xflip <= wdata[1];
                    attrs[slot_a].yflip <= wdata[0];
                end else begin
                    attrs[slot_a].pal   <= wdata;
                end
            end
            if (in_pos) begin
                if (!off_p[0]) attrs[slot_p].xpos <= wdata;
                else           attrs[slot_p].ypos <= wdata;
            end
        end
    end

    // R2
    outside_window_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!we || (!in_attr && !in_pos)) |=> $stable(attrs));
endmodule

// File: rtl/spr_hit_pick.sv
module spr_hit_pick
    import spr_pkg::*;
#(
    parameter int N_SPR  = 8,
    parameter int SCR_W  = 224,
    parameter int SCR_H  = 288,
    parameter int BORDER = 16,
    parameter int XW     = 8,
    parameter int YW     = 9
)(
    input  logic                  clk,
    input  logic                  rst,
    input  spr_attr_t [N_SPR-1:0] attrs,
    input  logic [XW-1:0]         pix_x,
    input  logic [YW-1:0]         pix_y,
    output logic                  hit_any,
    output spr_attr_t             sel,
    output logic [OFS_W-1:0]      rx,
    output logic [OFS_W-1:0]      ry
);
    localparam int CW = ((XW > YW) ? XW : YW) + 2;

    logic [N_SPR-1:0] hit_vec, grant;
    logic [OFS_W-1:0] dx_lo [N_SPR];
    logic [OFS_W-1:0] dy_lo [N_SPR];
    logic             row_ok;

    assign row_ok = (pix_y >= YW'(BORDER)) && (pix_y < YW'(SCR_H - BORDER));

    for (genvar g = 0; g < N_SPR; g++) begin : g_slot
        logic [CW-1:0] left_x, top_y, dx, dy;
        assign left_x     = CW'(SCR_W - SPR_DIM) - CW'(attrs[g].xpos);
        assign top_y      = CW'(SCR_H - SPR_DIM) - CW'(attrs[g].ypos);
        assign dx         = CW'(pix_x) - left_x;
        assign dy         = CW'(pix_y) - top_y;
        assign hit_vec[g] = row_ok && (dx < CW'(SPR_DIM)) && (dy < CW'(SPR_DIM));
        assign dx_lo[g]   = dx[OFS_W-1:0];
        assign dy_lo[g]   = dy[OFS_W-1:0];
    end

    always_comb begin
        grant = '0;
        sel   = '0;
        rx    = '0;
        ry    = '0;
        for (int i = N_SPR - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                grant = N_SPR'(1) << i;
                sel   = attrs[i];
                rx    = mirror_ofs(dx_lo[i], attrs[i].xflip);
                ry    = mirror_ofs(dy_lo[i], attrs[i].yflip);
            end
        end
        hit_any = |hit_vec;
    end

    // R5
    lowest_slot_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_vec != '0) |-> (grant == (hit_vec & (~hit_vec + 1'b1))));

    // R4
    blank_rows_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
        !row_ok |-> (hit_vec == '0));
endmodule

// File: rtl/spr_color_out.sv
module spr_color_out #(
    parameter logic [127:0] CTAB = 128'h0
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        hit_q,
    input  logic [1:0]  psel_q,
    input  logic [7:0]  rom_byte,
    input  logic [31:0] pal_word,
    output logic [7:0]  pix_color
);
    logic [1:0] pix2;
    logic [3:0] cidx;
    logic [7:0] col_d;

    always_comb begin
        pix2  = rom_byte[{psel_q, 1'b0} +: 2];
        cidx  = pal_word[{pix2, 3'b000} +: 4];
        col_d = hit_q ? CTAB[{cidx, 3'b000} +: 8] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) pix_color <= 8'h00;
        else     pix_color <= col_d;
    end

    // R1
    reset_black_chk: assert property (@(posedge clk)
        rst |=> (pix_color == 8'h00));

    // R6
    miss_black_chk: assert property (@(posedge clk) disable iff (rst)
        !hit_q |=> (pix_color == 8'h00));
endmodule

// File: rtl/sprite_layer.sv
module sprite_layer
    import spr_pkg::*;
#(
    parameter int           N_SPR     = 8,
    parameter int           SCR_W     = 224,
    parameter int           SCR_H     = 288,
    parameter int           BORDER    = 16,
    parameter logic [15:0]  ATTR_BASE = 16'h4FF0,
    parameter logic [15:0]  POS_BASE  = 16'h5060,
    parameter int           PAL_AW    = 5,
    parameter logic [127:0] CTAB      = 128'hF6AF_E8FC_3F58_C607_EF2F_7BF0_F6D6_0700,
    localparam int          XW        = $clog2(SCR_W),
    localparam int          YW        = $clog2(SCR_H),
    localparam int          ROM_AW    = PAT_W + 2 * OFS_W - 2
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_we,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic [XW-1:0]     pix_x,
    input  logic [YW-1:0]     pix_y,
    output logic [ROM_AW-1:0] spr_rom_addr,
    input  logic [7:0]        spr_rom_data,
    output logic [PAL_AW-1:0] pal_rom_addr,
    input  logic [31:0]       pal_rom_data,
    output logic [7:0]        pix_color
);
    spr_attr_t [N_SPR-1:0] attrs;
    spr_attr_t             sel;
    logic                  hit_any, hit_q;
    logic [OFS_W-1:0]      rx, ry;
    logic [1:0]            psel_q;

    spr_attr_bank #(.N_SPR(N_SPR), .ATTR_BASE(ATTR_BASE), .POS_BASE(POS_BASE)) u_bank (
        .clk(clk), .rst(rst), .we(cpu_we), .addr(cpu_addr), .wdata(cpu_wdata), .attrs(attrs)
    );

    spr_hit_pick #(.N_SPR(N_SPR), .SCR_W(SCR_W), .SCR_H(SCR_H), .BORDER(BORDER),
                   .XW(XW), .YW(YW)) u_pick (
        .clk(clk), .rst(rst), .attrs(attrs), .pix_x(pix_x), .pix_y(pix_y),
        .hit_any(hit_any), .sel(sel), .rx(rx), .ry(ry)
    );

    assign spr_rom_addr = {sel.pat, ry, rx[OFS_W-1:2]};
    assign pal_rom_addr = sel.pal[PAL_AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q  <= 1'b0;
            psel_q <= 2'd0;
        end else begin
            hit_q  <= hit_any;
            psel_q <= rx[1:0];
        end
    end

    spr_color_out #(.CTAB(CTAB)) u_col (
        .clk(clk), .rst(rst), .hit_q(hit_q), .psel_q(psel_q),
        .rom_byte(spr_rom_data), .pal_word(pal_rom_data), .pix_color(pix_color)
    );

    // R4, R10
    blank_row_output_chk: assert property (@(posedge clk) disable iff (rst)
        ((pix_y < YW'(BORDER)) || (pix_y >= YW'(SCR_H - BORDER))) |-> ##2 (pix_color == 8'h00));
endmodule

// File: tb/tb_sprite_layer.sv
module tb_sprite_layer;
    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_we;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic [7:0]  pix_x;
    logic [8:0]  pix_y;
    logic [11:0] spr_rom_addr;
    logic [7:0]  spr_rom_data;
    logic [4:0]  pal_rom_addr;
    logic [31:0] pal_rom_data;
    logic [7:0]  pix_color;

    localparam logic [127:0] CT = 128'hF6AF_E8FC_3F58_C607_EF2F_7BF0_F6D6_0700;

    always #4 clk = ~clk;

    sprite_layer dut (
        .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .pix_x(pix_x), .pix_y(pix_y), .spr_rom_addr(spr_rom_addr), .spr_rom_data(spr_rom_data),
        .pal_rom_addr(pal_rom_addr), .pal_rom_data(pal_rom_data), .pix_color(pix_color)
    );

    function automatic logic [7:0] srom(logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
    endfunction

    function automatic logic [31:0] prom(logic [4:0] p);
        logic [31:0] w;
        for (int k = 0; k < 4; k++) w[8*k +: 8] = {4'(k + 1), 4'(p * 3 + k * 5 + 1)};
        return w;
    endfunction

    always_ff @(posedge clk) begin
        spr_rom_data <= srom(spr_rom_addr);
        pal_rom_data <= prom(pal_rom_addr);
    end

    int sx [8], sy [8], spat [8], sxf [8], syf [8], spal [8];
    int n_chk = 0, n_fail = 0;

    function automatic logic [7:0] exp_col(int slot, int px, int py);
        int left, top, rx, ry, addr, pix, ci;
        logic [7:0]  b;
        logic [31:0] w;
        if (slot < 0) return 8'h00;
        left = 208 - sx[slot];
        top  = 272 - sy[slot];
        rx = px - left;
        ry = py - top;
        if (sxf[slot] != 0) rx = 15 - rx;
        if (syf[slot] != 0) ry = 15 - ry;
        addr = spat[slot] * 64 + ry * 4 + rx / 4;
        b    = srom(12'(addr));
        pix  = int'((b >> (2 * (rx % 4))) & 8'h3);
        w    = prom(5'(spal[slot]));
        ci   = int'((w >> (8 * pix)) & 32'hF);
        return CT[8*ci +: 8];
    endfunction

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: pix_color=%02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic cpu_wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic set_slot(int i, int x, int y, int pat, int xf, int yf, int pal);
        cpu_wr(16'h5060 + 16'(2 * i), 8'(x));
        cpu_wr(16'h5061 + 16'(2 * i), 8'(y));
        cpu_wr(16'h4FF0 + 16'(2 * i), {6'(pat), 1'(xf), 1'(yf)});
        cpu_wr(16'h4FF1 + 16'(2 * i), 8'(pal));
        sx[i] = x; sy[i] = y; spat[i] = pat; sxf[i] = xf; syf[i] = yf; spal[i] = pal;
    endtask

    task automatic probe(int px, int py, logic [7:0] exp, string tag);
        @(negedge clk);
        pix_x = 8'(px); pix_y = 9'(py);
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check(tag, pix_color, exp);
    endtask

    localparam int NP = 19;
    localparam int PRB [NP][3] = '{
        '{108, 172, 0}, '{123, 187, 0}, '{124, 180, 1}, '{115, 180, 0},
        '{127, 191, 1}, '{128, 191, -1}, '{107, 172, -1}, '{158, 72, 2},
        '{173, 87, 2},  '{174, 87, -1}, '{200, 271, 3}, '{200, 272, -1},
        '{8, 122, 7},   '{23, 137, 7},  '{0, 0, -1},    '{120, 171, -1},
        '{2, 175, 4},   '{4, 175, -1},  '{213, 262, 3}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] e_old, e_new;
        for (int i = 0; i < 8; i++) begin
            sx[i] = 0; sy[i] = 0; spat[i] = 0; sxf[i] = 0; syf[i] = 0; spal[i] = 0;
        end
        rst = 1'b1; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        pix_x = 8'd115; pix_y = 9'd180;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset output", pix_color, 8'h00);
        rst = 1'b0;
        probe(115, 180, 8'h00, "R1 R6 empty after reset");

        set_slot(0, 100, 100, 5, 0, 0, 3);
        set_slot(1, 96, 96, 9, 1, 0, 7);
        set_slot(2, 50, 200, 63, 0, 1, 31);
        set_slot(3, 10, 10, 1, 1, 1, 0);
        set_slot(4, 220, 100, 17, 0, 0, 20);
        set_slot(7, 200, 150, 33, 0, 0, 12);

        // R10: stream one probe per clock, result two edges later
        for (int i = 0; i < NP + 2; i++) begin
            @(negedge clk);
            if (i >= 2)
                check("R3 R5 R7 R8 R9 R10 table", pix_color,
                      exp_col(PRB[i-2][2], PRB[i-2][0], PRB[i-2][1]));
            if (i < NP) begin
                pix_x = 8'(PRB[i][0]); pix_y = 9'(PRB[i][1]);
            end
            @(posedge clk);
        end

        // R2: writes just outside both windows change nothing
        cpu_wr(16'h4FEF, 8'hFF);
        cpu_wr(16'h5070, 8'hFF);
        cpu_wr(16'h5050, 8'h00);
        cpu_wr(16'h4F00, 8'h00);
        probe(115, 180, exp_col(0, 115, 180), "R2 ignored writes keep slot 0");
        probe(124, 180, exp_col(1, 124, 180), "R2 ignored writes keep slot 1");

        // R10: write and scan of the same slot in the same cycle
        e_old = exp_col(0, 115, 180);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = 16'h5060; cpu_wdata = 8'd0;
        pix_x = 8'd115; pix_y = 9'd180;
        @(posedge clk);
        sx[0] = 0;
        e_new = exp_col(1, 115, 180);
        @(negedge clk);
        cpu_we = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R10 same-cycle write uses old attrs", pix_color, e_old);
        @(posedge clk);
        @(negedge clk);
        check("R5 R10 next pixel sees moved slot 0", pix_color, e_new);

        // R8: flip toggled on slot 1 changes the fetched pixel
        set_slot(1, 96, 96, 9, 0, 1, 7);
        probe(112, 176, exp_col(1, 112, 176), "R8 yflip only");

        // R1: mid-run reset clears all slots
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) begin
            sx[i] = 0; sy[i] = 0; spat[i] = 0; sxf[i] = 0; syf[i] = 0; spal[i] = 0;
        end
        probe(124, 180, 8'h00, "R1 R6 slots cleared by reset");
        probe(200, 271, 8'h00, "R1 R6 slot 3 cleared by reset");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule